// File: doc/BRIEF.md
# Serial Systematic (7,4) Cyclic Code Encoder

This block turns a four-bit message, delivered one bit per clock, into a seven-bit systematic codeword of the binary cyclic code generated by g(x) = 1 + x + x^3. A `start` pulse while the block is idle opens a frame and clears the division register. Message bits then enter one per clock with `din_valid`, most significant coefficient first (d3, d2, d1, d0). Each accepted bit goes straight to `code_out` in the same cycle. At the same time it feeds a three-stage feedback shift register that computes the remainder of x^3·d(x) divided by g(x).

The message bit is combined with the last register stage at the feedback point and not shifted in at the register input, so the premultiplication by x^3 takes no extra cycles. Once the fourth bit has been accepted, the output switch selects the register. The three remainder bits leave on the next three clocks, highest degree first (v2, v1, v0), with feedback turned off. The serial output therefore runs c6 down to c0, with c(x) = x^3·d(x) + v(x).

Control is a three-state machine. IDLE waits for `start`. DATA accepts message bits, holds its place when `din_valid` is low, and moves to PARITY after the fourth accepted bit. PARITY shifts out three bits and returns to IDLE on the third one. The transitions are IDLE→DATA (start), DATA→DATA (stall or bit accepted), DATA→PARITY (fourth bit accepted), PARITY→PARITY (parity bit with more to follow) and PARITY→IDLE (last parity bit).

Top module: `cyc_serial_encoder`

## Requirements
- R1: While reset is held and after reset is released, the block is idle with `code_valid` and `cw_done` both low.
- R2: A `start` seen in IDLE clears the three remainder stages to zero, so each codeword depends only on its own message, including when frames run back to back.
- R3: In DATA, whenever `din_valid` is high, `code_valid` is high and `code_out` equals `din` in that same cycle. When `din_valid` is low, `code_valid` is low and no bit is counted.
- R4: The clock after the fourth accepted message bit begins three consecutive cycles with `code_valid` high and no gaps. These cycles carry remainder bits v2, v1, v0 whatever `din_valid` does.
- R5: The seven valid output bits, taken in order as c6..c0, equal the message times the generator matrix over GF(2), with message bit i being coefficient d_i. The rows are d0→c0..c6 = 1101000, d1→0110100, d2→1110010 and d3→1010001. Message d0..d3 = 1,0,1,1 gives c0..c6 = 1,0,0,1,0,1,1. Every codeword polynomial is divisible by g(x).
- R6: `cw_done` is high for exactly one cycle per frame, together with the last parity bit, and the block is in IDLE on the next clock.
- R7: A `start` during DATA or PARITY is ignored. The running frame is not disturbed, and after the frame no data is accepted until a new `start`.
- R8: `din_valid` in IDLE or PARITY is ignored: no output is produced in IDLE, and the parity bits are unchanged.
- R9: Asserting reset in the middle of a frame abandons it and returns the block to IDLE. The next frame encodes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a frame when the block is idle |
| din_valid | input | 1 | Qualifies `din` during the data phase |
| din | input | 1 | Serial message bit, highest degree first |
| code_out | output | 1 | Serial codeword bit, c6 first |
| code_valid | output | 1 | `code_out` carries a codeword bit |
| cw_done | output | 1 | One-cycle pulse with the final parity bit |

## Verification
The assertions assume that `start`, `din_valid` and `din` are known values that change only away from the rising edge, and that reset is released away from an edge. The bench drives every input on the falling edge and samples the outputs one nanosecond later, so it meets both conditions. The assertions do not assume a well-behaved producer. The stimulus therefore adds random bubbles in `din_valid`, stray `start` pulses inside frames, and `din_valid` noise during parity, which exercises the ignore rules on purpose. Each frame is checked bit by bit against the matrix product and against the remainder test by g(x). All sixteen messages are covered, along with back-to-back frames and a reset in mid-frame.

// File: rtl/cyc_enc_pkg.sv
package cyc_enc_pkg;

    localparam int CODE_N   = 7;
    localparam int CODE_K   = 4;
    localparam int CODE_R   = CODE_N - CODE_K;
    localparam logic [CODE_R:0] GEN_POLY = 4'b1011;  // x^3 + x + 1, bit i = coefficient of x^i

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_PARITY = 2'd2
    } enc_state_e;

endpackage

// File: rtl/cyc_div_lfsr.sv
module cyc_div_lfsr #(
    parameter int               PAR_W = 3,
    parameter logic [PAR_W:0]   GEN   = 4'b1011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic feed_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic msb_o
);

    logic [PAR_W-1:0] rem_q;
    logic [PAR_W-1:0] rem_feed;
    logic [PAR_W-1:0] rem_shift;
    logic             fb;

    // Message enters at the feedback point: implicit multiply by x^PAR_W
    assign fb = bit_i ^ rem_q[PAR_W-1];

    for (genvar i = 0; i < PAR_W; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign rem_feed[i]  = GEN[0] & fb;
            assign rem_shift[i] = 1'b0;
        end else begin : g_rest
            assign rem_feed[i]  = rem_q[i-1] ^ (GEN[i] & fb);
            assign rem_shift[i] = rem_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (clear_i) begin
            rem_q <= '0;
        end else if (feed_i) begin
            rem_q <= rem_feed;
        end else if (shift_i) begin
            rem_q <= rem_shift;
        end
    end

    assign msb_o = rem_q[PAR_W-1];

    // R2: a frame opens with an empty remainder
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (rem_q == '0));

    // R4: with feedback off, the register moves one place toward the output
    assert_shift_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !feed_i && !clear_i) |=> (rem_q[PAR_W-1:1] == $past(rem_q[PAR_W-2:0])));

    // R4: only one operation per cycle on the register
    assert_one_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clear_i, feed_i, shift_i}));

endmodule

// File: rtl/cyc_frame_ctrl.sv
module cyc_frame_ctrl
    import cyc_enc_pkg::*;
#(
    parameter int MSG_K = 4,
    parameter int PAR_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       din_valid_i,
    output enc_state_e state_o,
    output logic       clear_o,
    output logic       accept_o,
    output logic       shift_o,
    output logic       last_o
);

    localparam int MAXC  = (MSG_K > PAR_W) ? MSG_K : PAR_W;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] DATA_END = CNT_W'(MSG_K - 1);
    localparam logic [CNT_W-1:0] PAR_END  = CNT_W'(PAR_W - 1);

    enc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_DATA;
                    cnt_d   = '0;
                end
            end
            ST_DATA: begin
                if (din_valid_i) begin
                    if (cnt_q == DATA_END) begin
                        state_d = ST_PARITY;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_PARITY: begin
                if (cnt_q == PAR_END) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        clear_o  = 1'b0;
        accept_o = 1'b0;
        shift_o  = 1'b0;
        last_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   clear_o  = start_i;
            ST_DATA:   accept_o = din_valid_i;
            ST_PARITY: begin
                shift_o = 1'b1;
                last_o  = (cnt_q == PAR_END);
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

    // R3: a stall holds both the phase and the bit count
    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !din_valid_i) |=> (state_q == ST_DATA && $stable(cnt_q)));

    // R4: parity shifting runs without interruption until the last bit
    assert_parity_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARITY && cnt_q != PAR_END) |=> (state_q == ST_PARITY));

    // R7: start inside the data phase never aborts the frame
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && start_i) |=> (state_q != ST_IDLE));

    // R6: leaving PARITY always lands in IDLE
    assert_parity_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARITY && cnt_q == PAR_END) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/cyc_out_switch.sv
module cyc_out_switch (
    input  logic accept_i,
    input  logic shift_i,
    input  logic last_i,
    input  logic din_i,
    input  logic par_bit_i,
    output logic code_out_o,
    output logic code_valid_o,
    output logic done_o
);

    always_comb begin
        if (shift_i) begin
            code_out_o = par_bit_i;
        end else if (accept_i) begin
            code_out_o = din_i;
        end else begin
            code_out_o = 1'b0;
        end
        code_valid_o = accept_i | shift_i;
        done_o       = last_i;
    end

endmodule

// File: rtl/cyc_serial_encoder.sv
module cyc_serial_encoder
    import cyc_enc_pkg::*;
#(
    parameter int              MSG_K = CODE_K,
    parameter int              PAR_W = CODE_R,
    parameter logic [PAR_W:0]  GEN   = GEN_POLY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic din_valid,
    input  logic din,
    output logic code_out,
    output logic code_valid,
    output logic cw_done
);

    enc_state_e state;
    logic       clear, accept, shift, last, par_bit;

    cyc_frame_ctrl #(
        .MSG_K (MSG_K),
        .PAR_W (PAR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .din_valid_i (din_valid),
        .state_o     (state),
        .clear_o     (clear),
        .accept_o    (accept),
        .shift_o     (shift),
        .last_o      (last)
    );

    cyc_div_lfsr #(
        .PAR_W (PAR_W),
        .GEN   (GEN)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .feed_i  (accept),
        .shift_i (shift),
        .bit_i   (din),
        .msb_o   (par_bit)
    );

    cyc_out_switch u_sw (
        .accept_i     (accept),
        .shift_i      (shift),
        .last_i       (last),
        .din_i        (din),
        .par_bit_i    (par_bit),
        .code_out_o   (code_out),
        .code_valid_o (code_valid),
        .done_o       (cw_done)
    );

    // R1 / R8: nothing leaves the block while it waits for a frame
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!code_valid && !cw_done));

    // R3: accepted message bits pass straight through in the same cycle
    assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && din_valid) |-> (code_valid && code_out == din));

    // R6: done is a single-cycle pulse that ends the frame
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cw_done |=> (!cw_done && state == ST_IDLE));

    // R6: done only ever accompanies a valid parity bit
    assert_done_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cw_done |-> (code_valid && state == ST_PARITY));

endmodule

// File: tb/test_cyc_serial_encoder.sv
`timescale 1ns/1ps
module test_cyc_serial_encoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic din_valid = 1'b0;
    logic din = 1'b0;
    logic code_out, code_valid, cw_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    cyc_serial_encoder i_cyc_serial_encoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .din_valid  (din_valid),
        .din        (din),
        .code_out   (code_out),
        .code_valid (code_valid),
        .cw_done    (cw_done)
    );

    // Reference: message times generator matrix; bit j of result = c_j
    function automatic logic [6:0] enc_ref(input logic [3:0] m);
        logic [6:0] rows [4];
        logic [6:0] c = '0;
        rows[0] = 7'b0001011;
        rows[1] = 7'b0010110;
        rows[2] = 7'b0100111;
        rows[3] = 7'b1000101;
        for (int i = 0; i < 4; i++) if (m[i]) c ^= rows[i];
        return c;
    endfunction

    function automatic logic [2:0] gmod(input logic [6:0] c);
        logic [6:0] r = c;
        for (int i = 6; i >= 3; i--) if (r[i]) r ^= (7'b0001011 << (i - 3));
        return r[2:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One frame: bubble_pct = chance of a stall per data cycle; noise = stray start/din_valid
    task automatic run_frame(input logic [3:0] msg, input int bubble_pct,
                             input bit noise, input bit idle_probe);
        logic [6:0] got = '0;
        logic [6:0] exp = enc_ref(msg);
        int nval = 0;
        int sent = 0;
        int cyc = 0;
        bit done_seen = 1'b0;
        bit dv;
        @(negedge clk);
        start = 1'b1; din_valid = 1'b0; din = 1'b0;
        #1 chk(!code_valid && !cw_done, "R1 idle before start", code_valid, 0);
        while (nval < 7 && cyc < 40) begin
            @(negedge clk);
            start = noise ? (($urandom % 3) == 0) : 1'b0;
            if (sent < 4) begin
                dv = (int'($urandom % 100) >= bubble_pct);
                din_valid = dv;
                din = dv ? msg[3 - sent] : 1'(($urandom % 2));
            end else begin
                dv = 1'b0;
                din_valid = noise ? 1'(($urandom % 2)) : 1'b0;
                din = 1'(($urandom % 2));
            end
            #1;
            if (sent < 4) begin
                if (dv) chk(code_valid && code_out == din, "R3 passthrough", {code_valid, code_out}, {1'b1, din});
                else    chk(!code_valid, "R3 stall", code_valid, 0);
            end else begin
                chk(code_valid, "R4 parity run", code_valid, 1);
            end
            if (code_valid) begin
                got = {got[5:0], code_out};
                nval++;
            end
            if (cw_done) begin
                chk(nval == 7, "R6 done position", nval, 7);
                done_seen = 1'b1;
            end
            if (dv) sent++;
            cyc++;
        end
        start = 1'b0;
        chk(nval == 7 && done_seen, "R6 done seen", {done_seen, 4'(nval)}, {1'b1, 4'd7});
        chk(got == exp, "R5 matrix product", got, exp);
        chk(gmod(got) == 3'b000, "R5 divisible by g", gmod(got), 0);
        if (idle_probe) begin
            @(negedge clk);
            start = 1'b0; din_valid = 1'b1; din = 1'b1;
            #1 chk(!code_valid && !cw_done, "R7/R8 idle after frame", {code_valid, cw_done}, 0);
            @(negedge clk);
            din_valid = 1'b0;
            #1 chk(!cw_done, "R6 single pulse", cw_done, 0);
        end
        din_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5A17));
        // R1: reset state
        #1 chk(!code_valid && !cw_done, "R1 in reset", {code_valid, cw_done}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        din_valid = 1'b1; din = 1'b1;
        #1 chk(!code_valid && !cw_done, "R1/R8 idle after reset", {code_valid, cw_done}, 0);
        din_valid = 1'b0;

        // R5: worked example d0..d3 = 1,0,1,1 -> c0..c6 = 1,0,0,1,0,1,1
        chk(enc_ref(4'b1101) == 7'b1101001, "R5 reference example", enc_ref(4'b1101), 7'h69);
        run_frame(4'b1101, 0, 1'b0, 1'b1);

        // R5: every message, no stalls
        for (int m = 0; m < 16; m++) run_frame(4'(m), 0, 1'b0, 1'b1);

        // R2: back-to-back frames, ones then zeros then ones
        run_frame(4'b1111, 0, 1'b0, 1'b0);
        run_frame(4'b0000, 0, 1'b0, 1'b0);
        run_frame(4'b1000, 0, 1'b0, 1'b1);

        // R3 / R7 / R8: random messages with stalls and stray inputs
        for (int n = 0; n < 60; n++) run_frame(4'($urandom % 16), 40, 1'b1, 1'b1);

        // R9: reset in the middle of a frame
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; din_valid = 1'b1; din = 1'b1;
        @(negedge clk); din = 1'b0;
        @(negedge clk); rst_n = 1'b0; din_valid = 1'b0;
        #1 chk(!code_valid && !cw_done, "R9 reset mid-frame", {code_valid, cw_done}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); din_valid = 1'b1;
        #1 chk(!code_valid, "R9 idle after reset", code_valid, 0);
        din_valid = 1'b0;
        run_frame(4'b0110, 0, 1'b0, 1'b1);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule